// File: doc/BRIEF.md
# Flag-Setting Data-Processing Unit

This unit performs the arithmetic or logical step of a 32-bit register-to-register instruction. It takes an operation code, a set-flags bit, the destination register index, a first operand, a second operand already prepared by the shifter, the shifter's carry-out and the present N/Z/C/V condition flags. From these it produces the result and its write enable, the next flag values with an update enable, a request to restore the saved status word, and an undefined-operation indication.

All outputs are registered. Inputs presented before a rising clock edge appear on the outputs after that edge, one cycle of latency. The unit accepts a new operation every cycle. Flags are packed as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V on both the input and the output.

Top module: `dp_alu`

## Requirements
- R1: After a synchronous active-high reset, result, flags_out and all enables read zero. Every output then reflects the inputs sampled at the previous rising edge.
- R2: Logical codes produce: 0 = op_a AND op_b, 1 = op_a XOR op_b, 12 = op_a OR op_b, 13 = op_b, 14 = op_a AND NOT op_b, 15 = NOT op_b. Each asserts reg_we.
- R3: Arithmetic codes produce: 2 = op_a - op_b, 3 = op_b - op_a, 4 = op_a + op_b, 5 = op_a + op_b + C, 6 = op_a - op_b - NOT C, 7 = op_b - op_a - NOT C. Each asserts reg_we.
- R4: With set_flags high, an arithmetic operation sets C to the unsigned carry-out of an add, and for a subtract sets C to 1 exactly when no borrow occurs, the subtrahend (plus borrow-in) not exceeding the minuend.
- R5: With set_flags high, an arithmetic operation sets V when the signed result does not fit in 32 bits, N from result bit 31 and Z when the result is zero.
- R6: With set_flags high, a logical operation sets N from result bit 31, Z when the result is zero, C from shift_c, and leaves V at its input value.
- R7: Codes 8 (AND), 9 (XOR), 10 (subtract) and 11 (add) with set_flags high update the flags as R4 to R6 describe but never assert reg_we or restore_req, whatever rd_idx holds.
- R8: With set_flags low, flags_we is low and flags_out equals the flags presented with the operation.
- R9: With set_flags high, a writing operation (codes 0 to 7 and 12 to 15) whose rd_idx is 15 still asserts reg_we with the result, holds the flags, deasserts flags_we and asserts restore_req.
- R10: Codes 8 to 11 with set_flags low assert undef_op and assert neither reg_we nor flags_we. Flags are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Operation code |
| set_flags | input | 1 | Request to update the condition flags |
| rd_idx | input | 4 | Destination register index |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand from the shifter |
| shift_c | input | 1 | Shifter carry-out |
| flags_in | input | 4 | Current N, Z, C, V |
| result | output | 32 | Operation result |
| reg_we | output | 1 | Result is to be written to rd_idx |
| flags_out | output | 4 | Next N, Z, C, V |
| flags_we | output | 1 | Flags are to be updated |
| restore_req | output | 1 | Request to restore the saved status word |
| undef_op | output | 1 | Code not valid as a data operation |

## Verification
The assertions assume every input is a known value on each rising edge, and that the flags on flags_in belong to the operation presented in the same cycle. The hold and V-retention checks compare flags_out with the flags sampled one edge earlier, so they wait until one full cycle has passed since reset. The bench drives every input at the falling edge with concrete values. It covers all sixteen codes, both set_flags values and destination 15, and never leaves an input undriven.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } dp_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic op_is_arith(input dp_op_e op);
    return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN});
  endfunction

  function automatic logic op_is_test(input dp_op_e op);
    return (op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN});
  endfunction
endpackage

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
  import dp_pkg::*;
#(
  parameter int W = 32
) (
  input  dp_op_e         op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  always_comb begin
    case (op)
      OP_AND, OP_TST: y = a & b;
      OP_EOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_MOV:         y = b;
      OP_BIC:         y = a & ~b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end
endmodule

// File: rtl/dp_add_unit.sv
module dp_add_unit
  import dp_pkg::*;
#(
  parameter int W = 32
) (
  input  dp_op_e         op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           c_in,
  output logic [W-1:0]   sum,
  output logic           c_out,
  output logic           ovf
);
  localparam int MSB = W - 1;

  logic [W-1:0] x, y;
  logic         ci;
  logic [W:0]   full;

  // Operand steering: subtraction is x + ~y + carry-in, so C reads "no borrow".
  always_comb begin
    case (op)
      OP_SUB, OP_CMP: begin x = a; y = ~b; ci = 1'b1; end
      OP_RSB:         begin x = b; y = ~a; ci = 1'b1; end
      OP_ADC:         begin x = a; y = b;  ci = c_in; end
      OP_SBC:         begin x = a; y = ~b; ci = c_in; end
      OP_RSC:         begin x = b; y = ~a; ci = c_in; end
      default:        begin x = a; y = b;  ci = 1'b0; end
    endcase
  end

  assign full  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  assign sum   = full[W-1:0];
  assign c_out = full[W];
  assign ovf   = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
endmodule

// File: rtl/dp_ctrl.sv
module dp_ctrl
  import dp_pkg::*;
#(
  parameter int RIDX_W = 4,
  parameter int PC_IDX = 15
) (
  input  dp_op_e            op,
  input  logic              s_bit,
  input  logic [RIDX_W-1:0] rd,
  output logic              wr_en,
  output logic              flag_upd,
  output logic              restore,
  output logic              undef
);
  localparam logic [RIDX_W-1:0] PC_SEL = RIDX_W'(PC_IDX);

  logic is_test, to_pc;

  assign is_test  = op_is_test(op);
  assign to_pc    = (rd == PC_SEL);
  assign undef    = is_test && !s_bit;
  assign wr_en    = !is_test;
  assign restore  = s_bit && !is_test && to_pc;
  assign flag_upd = s_bit && !(!is_test && to_pc);
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int W      = 32,
  parameter int RIDX_W = 4,
  parameter int PC_IDX = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        opcode,
  input  logic              set_flags,
  input  logic [RIDX_W-1:0] rd_idx,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic              shift_c,
  input  logic [3:0]        flags_in,
  output logic [W-1:0]      result,
  output logic              reg_we,
  output logic [3:0]        flags_out,
  output logic              flags_we,
  output logic              restore_req,
  output logic              undef_op
);
  localparam int MSB = W - 1;

  dp_op_e       op;
  nzcv_t        cur, nxt;
  logic [W-1:0] logic_y, arith_y, res_c;
  logic         a_cout, a_ovf, arith;
  logic         wr_c, upd_c, rest_c, und_c;

  assign op    = dp_op_e'(opcode);
  assign cur   = nzcv_t'(flags_in);
  assign arith = op_is_arith(op);

  dp_logic_unit #(.W(W)) u_logic (
    .op(op), .a(op_a), .b(op_b), .y(logic_y)
  );

  dp_add_unit #(.W(W)) u_add (
    .op(op), .a(op_a), .b(op_b), .c_in(cur.c),
    .sum(arith_y), .c_out(a_cout), .ovf(a_ovf)
  );

  dp_ctrl #(.RIDX_W(RIDX_W), .PC_IDX(PC_IDX)) u_ctrl (
    .op(op), .s_bit(set_flags), .rd(rd_idx),
    .wr_en(wr_c), .flag_upd(upd_c), .restore(rest_c), .undef(und_c)
  );

  assign res_c = arith ? arith_y : logic_y;

  always_comb begin
    nxt = cur;
    if (upd_c) begin
      nxt.n = res_c[MSB];
      nxt.z = (res_c == '0);
      nxt.c = arith ? a_cout : shift_c;
      nxt.v = arith ? a_ovf : cur.v;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result      <= '0;
      reg_we      <= 1'b0;
      flags_out   <= '0;
      flags_we    <= 1'b0;
      restore_req <= 1'b0;
      undef_op    <= 1'b0;
    end else begin
      result      <= res_c;
      reg_we      <= wr_c;
      flags_out   <= nxt;
      flags_we    <= upd_c;
      restore_req <= rest_c;
      undef_op    <= und_c;
    end
  end

  // Marks that one full cycle has elapsed since reset, for $past-based checks.
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  a_r10_undef_quiet: assert property (@(posedge clk) disable iff (rst)
    undef_op |-> (!reg_we && !flags_we));

  a_r9_restore_writes: assert property (@(posedge clk) disable iff (rst)
    restore_req |-> (reg_we && !flags_we));

  a_r8_flags_held: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !flags_we) |-> (flags_out == $past(flags_in)));

  a_r6_v_kept: assert property (@(posedge clk) disable iff (rst)
    (past_ok && flags_we && !$past(arith)) |-> (flags_out[0] == $past(flags_in[0])));

  a_r7_test_no_write: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(opcode[3:2] == 2'b10)) |-> (!reg_we && !restore_req));
endmodule

// File: tb/dp_alu_test.sv
module dp_alu_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  opcode;
  logic        set_flags;
  logic [3:0]  rd_idx;
  logic [31:0] op_a, op_b;
  logic        shift_c;
  logic [3:0]  flags_in;
  logic [31:0] result;
  logic        reg_we, flags_we, restore_req, undef_op;
  logic [3:0]  flags_out;

  always #4 clk = ~clk;

  dp_alu uut (
    .clk(clk), .rst(rst), .opcode(opcode), .set_flags(set_flags), .rd_idx(rd_idx),
    .op_a(op_a), .op_b(op_b), .shift_c(shift_c), .flags_in(flags_in),
    .result(result), .reg_we(reg_we), .flags_out(flags_out), .flags_we(flags_we),
    .restore_req(restore_req), .undef_op(undef_op)
  );

  typedef struct {
    logic [31:0] res;
    logic        we, fwe, rr, ud;
    logic [3:0]  fl;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  bit   done = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [3:0] op, input logic s, input logic [3:0] rd,
                                 input logic [31:0] a, input logic [31:0] b,
                                 input logic sc, input logic [3:0] f);
    exp_t e;
    longint sa, sb, sr;
    logic [32:0] ua;
    logic cin, nb, c, v, test, arith;
    cin = f[1]; nb = !cin;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    c = 1'b0; v = f[0];
    test = (op >= 8 && op <= 11);
    arith = (op >= 2 && op <= 7) || op == 10 || op == 11;
    case (op)
      0, 8:  e.res = a & b;
      1, 9:  e.res = a ^ b;
      12:    e.res = a | b;
      13:    e.res = b;
      14:    e.res = a & ~b;
      15:    e.res = ~b;
      2, 10: begin e.res = a - b; c = ({1'b0,a} >= {1'b0,b}); sr = sa - sb; end
      3:     begin e.res = b - a; c = ({1'b0,b} >= {1'b0,a}); sr = sb - sa; end
      4, 11: begin ua = {1'b0,a} + {1'b0,b}; e.res = ua[31:0]; c = ua[32]; sr = sa + sb; end
      5:     begin ua = {1'b0,a} + {1'b0,b} + 33'(cin); e.res = ua[31:0]; c = ua[32]; sr = sa + sb + longint'(cin); end
      6:     begin e.res = a - b - 32'(nb); c = ({1'b0,a} >= {1'b0,b} + 33'(nb)); sr = sa - sb - longint'(nb); end
      default: begin e.res = b - a - 32'(nb); c = ({1'b0,b} >= {1'b0,a} + 33'(nb)); sr = sb - sa - longint'(nb); end
    endcase
    if (arith) v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    else c = sc;
    e.we  = !test;
    e.ud  = test && !s;
    e.rr  = s && !test && rd == 4'd15;
    e.fwe = s && !e.rr;
    e.fl  = e.fwe ? {e.res[31], e.res == 32'd0, c, v} : f;
    if (e.ud) e.tag = "R10";
    else if (e.rr) e.tag = "R9";
    else if (!s) e.tag = "R8";
    else if (test) e.tag = "R7";
    else if (arith) e.tag = "R4/R5";
    else e.tag = "R6";
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic s, input logic [3:0] rd,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic sc, input logic [3:0] f);
    @(negedge clk);
    opcode = op; set_flags = s; rd_idx = rd; op_a = a; op_b = b; shift_c = sc; flags_in = f;
    q.push_back(model(op, s, rd, a, b, sc, f));
  endtask

  // Monitor: results of inputs driven at a falling edge appear after the next rising edge.
  initial begin
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        // R2/R3: result value; R1: one-cycle registered latency
        chk((e.tag == "R4/R5") ? "R3" : (e.tag == "R6" ? "R2" : e.tag), "result", result, e.res);
        chk(e.tag, "reg_we", 32'(reg_we), 32'(e.we));
        chk(e.tag, "flags_out", 32'(flags_out), 32'(e.fl));
        chk(e.tag, "flags_we", 32'(flags_we), 32'(e.fwe));
        chk(e.tag, "restore_req", 32'(restore_req), 32'(e.rr));
        chk(e.tag, "undef_op", 32'(undef_op), 32'(e.ud));
      end
    end
  end

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; opcode = 4'd4; set_flags = 1'b1; rd_idx = 4'd1;
    op_a = 32'hFFFF_FFFF; op_b = 32'h1; shift_c = 1'b1; flags_in = 4'hF;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1", "result", result, 32'd0);
    chk("R1", "enables", {28'd0, reg_we, flags_we, restore_req, undef_op}, 32'd0);
    chk("R1", "flags_out", 32'(flags_out), 32'd0);
    @(negedge clk); rst = 1'b0;

    // R2 logical ops, with and without S
    drive(0,  1, 2, 32'hF0F0_1234, 32'h0FF0_FF00, 1, 4'b0001);
    drive(1,  1, 2, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 0, 4'b1111); // R6: zero result, V kept
    drive(12, 0, 3, 32'h1200_0000, 32'h0000_0034, 0, 4'b0110);
    drive(13, 1, 3, 32'h0,         32'h8000_0000, 1, 4'b0000); // R6: N from bit 31, C from shift_c
    drive(14, 1, 4, 32'hFFFF_FFFF, 32'h0000_FFFF, 0, 4'b0011);
    drive(15, 0, 5, 32'h0,         32'h1234_5678, 1, 4'b1010);
    // R3/R4/R5 arithmetic corners
    drive(2, 1, 1, 32'd5, 32'd5, 0, 4'b0000);                  // equal: Z=1, C=1
    drive(2, 1, 1, 32'd0, 32'd1, 1, 4'b0000);                  // borrow: C=0, N=1
    drive(2, 1, 1, 32'h8000_0000, 32'd1, 0, 4'b0000);          // signed overflow
    drive(3, 1, 1, 32'd3, 32'd10, 0, 4'b0000);                 // reverse subtract
    drive(4, 1, 1, 32'h7FFF_FFFF, 32'd1, 0, 4'b0000);          // add overflow
    drive(4, 1, 1, 32'hFFFF_FFFF, 32'd1, 0, 4'b0000);          // add carry, zero
    drive(5, 1, 1, 32'hFFFF_FFFF, 32'd0, 0, 4'b0010);          // add with carry-in
    drive(6, 1, 1, 32'd7, 32'd7, 0, 4'b0000);                  // sbc with C=0 borrows
    drive(6, 1, 1, 32'd7, 32'd7, 0, 4'b0010);                  // sbc with C=1
    drive(7, 1, 1, 32'd2, 32'd2, 0, 4'b0000);                  // rsc with C=0
    // R7 compare/test with S, rd=15 ignored
    drive(8,  1, 15, 32'hFF, 32'h100, 1, 4'b0001);
    drive(9,  1, 15, 32'h5, 32'h5, 0, 4'b1001);
    drive(10, 1, 15, 32'd1, 32'd2, 0, 4'b0010);
    drive(11, 1, 0,  32'h8000_0000, 32'h8000_0000, 0, 4'b0000);
    // R9 destination 15 with S
    drive(4,  1, 15, 32'd1, 32'd2, 0, 4'b0101);
    drive(13, 1, 15, 32'h0, 32'h0, 1, 4'b1010);
    // R8 S clear holds flags
    drive(2, 0, 15, 32'd0, 32'd1, 0, 4'b1101);
    // R10 test codes with S clear
    for (int k = 8; k < 12; k++) drive(4'(k), 0, 4'(k), 32'd9, 32'd9, 1, 4'b0110);
    // Mixed patterns
    for (int i = 0; i < 300; i++)
      drive(4'($urandom), 1'($urandom), 4'($urandom % 3 == 0 ? 15 : $urandom),
            (i % 5 == 0) ? 32'h8000_0000 : $urandom, (i % 7 == 0) ? 32'hFFFF_FFFF : $urandom,
            1'($urandom), 4'($urandom));
    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule